// File: doc/BRIEF.md
# Linked-Channel PWM Compare Timer

A free-running up-counter with a programmable wrap value drives two output-compare pins. Each pin can invert itself whenever the counter wraps, and can be forced to a chosen level when the count equals that channel's compare value. Together these two actions produce a PWM waveform. The wrap value sets the period, and the compare value sets the pulse width.

A link bit in channel 0's control joins the two compare registers into one double-buffered unit that drives channel 0's pin. Software loads the idle register while the other one keeps governing the pin. At the next wrap, control passes to the register that was written most recently, so a duty change never cuts a period short. While linked, channel 1's pin is released and simply follows a general-purpose input.

Top module: `linked_compare_timer`

## Requirements
- R1: While reset is held, count is 0, both pins are low, ovf is low unless the wrap value is 0, and active_ch and switch_pending are 0.
- R2: The count rises by one per clock. ovf is high for the single cycle in which count equals the wrap value (address 0), and on the next clock count returns to 0, so the period is wrap+1 cycles.
- R3: When control bit 1 (invert-on-wrap) is set, the clock edge at which ovf is high inverts the pin. When the bit is clear, the wrap leaves the pin unchanged.
- R4: At the clock edge where count equals the governing compare value, the pin takes the value of control bit 2 (1 = set, 0 = clear). This match wins over a coincident inversion.
- R5: A compare value above the wrap value never matches, so the pin changes only at wrap edges and holds one level for each whole period.
- R6: With the link bit clear, channel 1 drives ch1_pin from its own compare value (address 2) and control (address 4), independently of channel 0.
- R7: Setting control bit 0 of channel 0 (address 3) links the channels. ch0_pin then follows channel 0's control bits and the compare register selected by active_ch (0 = address 1, 1 = address 2). active_ch is 0 on entry and returns to 0 when the link is cleared.
- R8: While linked, writing the compare register of the inactive channel raises switch_pending. active_ch flips only at the clock edge where ovf is high and switch_pending is set. If a write coincides with that edge, the handover is applied first and the write is then judged against the new active channel.
- R9: The last compare write in a period wins. A later write to the active channel's register clears switch_pending, and a completed handover clears it.
- R10: A write to the active channel's compare register is used for matching from the next clock, within the current period.
- R11: While linked, ch1_pin equals gp_in, channel 1's control register has no effect on any pin, and channel 1's internal pin state is frozen.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous reset, active high |
| wr_en | input | 1 | Register write strobe |
| wr_addr | input | 3 | 0 wrap value, 1 compare 0, 2 compare 1, 3 control 0, 4 control 1 |
| wr_data | input | CNT_W | Write data; control uses bits [2:0] |
| gp_in | input | 1 | General-purpose level routed to ch1_pin while linked |
| ch0_pin | output | 1 | Channel 0 / linked compare output |
| ch1_pin | output | 1 | Channel 1 compare output or gp_in |
| active_ch | output | 1 | Compare register currently governing ch0_pin when linked |
| switch_pending | output | 1 | A handover is scheduled for the next wrap |
| ovf | output | 1 | Wrap strobe, high while count equals wrap value |
| count | output | CNT_W | Current counter value |

## Verification
The bench builds the block with CNT_W set to 8. This brings a full-range wrap value of 255 within a few hundred cycles and lets the counter boundary be checked at the top of its width. Most scenarios use a wrap value of 9, so each period is ten cycles and many linked handovers, last-write-wins cases and immediate active-register rewrites fit into one short run. A cycle-by-cycle reference of the requirements scores every output, and duty counts per period are checked directly.

// File: rtl/lct_pkg.sv
package lct_pkg;
    localparam logic [2:0] ADDR_WRAP = 3'd0;
    localparam logic [2:0] ADDR_CMP0 = 3'd1;
    localparam logic [2:0] ADDR_CMP1 = 3'd2;
    localparam logic [2:0] ADDR_CTL0 = 3'd3;
    localparam logic [2:0] ADDR_CTL1 = 3'd4;

    localparam int CTL_LINK_BIT = 0;
    localparam int CTL_INV_BIT  = 1;
    localparam int CTL_LVL_BIT  = 2;

    // per-pin behaviour selected by a control register
    typedef struct packed {
        logic inv_on_wrap;
        logic match_lvl;
    } pin_cfg_t;
endpackage

// File: rtl/lct_counter.sv
module lct_counter #(
    parameter int W = 16
) (
    input  logic         clk,
    input  logic         rst,
    input  logic [W-1:0] wrap_val,
    output logic [W-1:0] count,
    output logic         ovf
);
    typedef struct packed {
        logic [W-1:0] cnt;
    } cnt_st_t;

    cnt_st_t s_d, s_q;

    always_comb begin
        ovf      = (s_q.cnt == wrap_val);
        s_d      = s_q;
        s_d.cnt  = ovf ? '0 : s_q.cnt + 1'b1;
    end

    always_ff @(posedge clk) begin
        if (rst) s_q <= '0;
        else     s_q <= s_d;
    end

    assign count = s_q.cnt;

    // R2
    wrap_zero_chk: assert property (@(posedge clk) disable iff (rst)
        ovf |=> (s_q.cnt == '0));

    // R2
    count_step_chk: assert property (@(posedge clk) disable iff (rst)
        !ovf |=> (s_q.cnt == W'($past(s_q.cnt) + 1'b1)));
endmodule

// File: rtl/lct_regs.sv
module lct_regs
    import lct_pkg::*;
#(
    parameter int W = 16
) (
    input  logic         clk,
    input  logic         rst,
    input  logic         wr_en,
    input  logic [2:0]   wr_addr,
    input  logic [W-1:0] wr_data,
    input  logic         ovf,
    output logic [W-1:0] wrap_val,
    output logic [W-1:0] cmp0,
    output logic [W-1:0] cmp1,
    output pin_cfg_t     cfg0,
    output pin_cfg_t     cfg1,
    output logic         link,
    output logic         active,
    output logic         pending
);
    typedef struct packed {
        logic [W-1:0] wrap;
        logic [W-1:0] c0;
        logic [W-1:0] c1;
        pin_cfg_t     k0;
        pin_cfg_t     k1;
        logic         lnk;
        logic         act;
        logic         pend;
    } reg_st_t;

    reg_st_t s_d, s_q;
    logic    cw0, cw1, next_act;

    always_comb begin
        s_d      = s_q;
        cw0      = wr_en && (wr_addr == ADDR_CMP0);
        cw1      = wr_en && (wr_addr == ADDR_CMP1);
        next_act = (ovf && s_q.pend) ? ~s_q.act : s_q.act;

        if (!s_q.lnk) begin
            s_d.act  = 1'b0;
            s_d.pend = 1'b0;
        end else begin
            s_d.act = next_act;
            if (cw0)      s_d.pend = (next_act != 1'b0);
            else if (cw1) s_d.pend = (next_act != 1'b1);
            else if (ovf) s_d.pend = 1'b0;
        end

        if (wr_en) begin
            case (wr_addr)
                ADDR_WRAP: s_d.wrap = wr_data;
                ADDR_CMP0: s_d.c0   = wr_data;
                ADDR_CMP1: s_d.c1   = wr_data;
                ADDR_CTL0: begin
                    s_d.lnk            = wr_data[CTL_LINK_BIT];
                    s_d.k0.inv_on_wrap = wr_data[CTL_INV_BIT];
                    s_d.k0.match_lvl   = wr_data[CTL_LVL_BIT];
                end
                ADDR_CTL1: begin
                    s_d.k1.inv_on_wrap = wr_data[CTL_INV_BIT];
                    s_d.k1.match_lvl   = wr_data[CTL_LVL_BIT];
                end
                default: ;
            endcase
        end
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            s_q      <= '0;
            s_q.wrap <= '1;
            s_q.c0   <= '1;
            s_q.c1   <= '1;
        end else begin
            s_q <= s_d;
        end
    end

    assign wrap_val = s_q.wrap;
    assign cmp0     = s_q.c0;
    assign cmp1     = s_q.c1;
    assign cfg0     = s_q.k0;
    assign cfg1     = s_q.k1;
    assign link     = s_q.lnk;
    assign active   = s_q.act;
    assign pending  = s_q.pend;

    // R8
    handover_at_wrap_chk: assert property (@(posedge clk) disable iff (rst)
        (s_q.lnk && (s_q.act != $past(s_q.act))) |-> $past(ovf && s_q.pend));

    // R9
    pending_clear_chk: assert property (@(posedge clk) disable iff (rst)
        (s_q.lnk && ovf && s_q.pend && !cw0 && !cw1) |=> !s_q.pend);

    // R7
    unlinked_idle_chk: assert property (@(posedge clk) disable iff (rst)
        !$past(s_q.lnk) |-> (!s_q.act && !s_q.pend));
endmodule

// File: rtl/lct_pin.sv
module lct_pin
    import lct_pkg::*;
#(
    parameter int W = 16
) (
    input  logic         clk,
    input  logic         rst,
    input  logic         hold,
    input  logic [W-1:0] count,
    input  logic         ovf,
    input  logic [W-1:0] cmp,
    input  pin_cfg_t     cfg,
    output logic         pin
);
    typedef struct packed {
        logic level;
    } pin_st_t;

    pin_st_t s_d, s_q;
    logic    match;

    always_comb begin
        match = (count == cmp);
        s_d   = s_q;
        if (!hold) begin
            if (match)                       s_d.level = cfg.match_lvl;
            else if (ovf && cfg.inv_on_wrap) s_d.level = ~s_q.level;
        end
    end

    always_ff @(posedge clk) begin
        if (rst) s_q <= '0;
        else     s_q <= s_d;
    end

    assign pin = s_q.level;

    // R4
    match_level_chk: assert property (@(posedge clk) disable iff (rst)
        (!hold && match) |=> (s_q.level == $past(cfg.match_lvl)));

    // R5
    quiet_hold_chk: assert property (@(posedge clk) disable iff (rst)
        (hold || (!match && !ovf)) |=> $stable(s_q.level));
endmodule

// File: rtl/linked_compare_timer.sv
module linked_compare_timer
    import lct_pkg::*;
#(
    parameter int CNT_W = 16
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             wr_en,
    input  logic [2:0]       wr_addr,
    input  logic [CNT_W-1:0] wr_data,
    input  logic             gp_in,
    output logic             ch0_pin,
    output logic             ch1_pin,
    output logic             active_ch,
    output logic             switch_pending,
    output logic             ovf,
    output logic [CNT_W-1:0] count
);
    localparam int NCH = 2;

    logic [CNT_W-1:0] wrap_val, cmp0, cmp1, cnt;
    pin_cfg_t         cfg0, cfg1;
    logic             link, act, pend, ovf_w;

    logic [CNT_W-1:0] cmp_v [NCH];
    pin_cfg_t         cfg_v [NCH];
    logic             hold_v[NCH];
    logic             pin_v [NCH];

    lct_counter #(.W(CNT_W)) u_cnt (
        .clk      (clk),
        .rst      (rst),
        .wrap_val (wrap_val),
        .count    (cnt),
        .ovf      (ovf_w)
    );

    lct_regs #(.W(CNT_W)) u_regs (
        .clk      (clk),
        .rst      (rst),
        .wr_en    (wr_en),
        .wr_addr  (wr_addr),
        .wr_data  (wr_data),
        .ovf      (ovf_w),
        .wrap_val (wrap_val),
        .cmp0     (cmp0),
        .cmp1     (cmp1),
        .cfg0     (cfg0),
        .cfg1     (cfg1),
        .link     (link),
        .active   (act),
        .pending  (pend)
    );

    always_comb begin
        cmp_v[0]  = (link && act) ? cmp1 : cmp0;
        cfg_v[0]  = cfg0;
        hold_v[0] = 1'b0;
        cmp_v[1]  = cmp1;
        cfg_v[1]  = cfg1;
        hold_v[1] = link;
    end

    for (genvar g = 0; g < NCH; g++) begin : g_pin
        lct_pin #(.W(CNT_W)) u_pin (
            .clk   (clk),
            .rst   (rst),
            .hold  (hold_v[g]),
            .count (cnt),
            .ovf   (ovf_w),
            .cmp   (cmp_v[g]),
            .cfg   (cfg_v[g]),
            .pin   (pin_v[g])
        );
    end

    assign ch0_pin        = pin_v[0];
    assign ch1_pin        = link ? gp_in : pin_v[1];
    assign active_ch      = act;
    assign switch_pending = pend;
    assign ovf            = ovf_w;
    assign count          = cnt;
endmodule

// File: tb/tb_linked_compare_timer.sv
`timescale 1ns/1ps
module tb_linked_compare_timer;
    localparam int W = 8;

    logic         clk = 1'b0;
    logic         rst;
    logic         wr_en;
    logic [2:0]   wr_addr;
    logic [W-1:0] wr_data;
    logic         gp_in;
    logic         ch0_pin, ch1_pin, active_ch, switch_pending, ovf;
    logic [W-1:0] count;

    int n_chk  = 0;
    int n_fail = 0;
    bit done   = 0;

    always #2.5 clk = ~clk;

    linked_compare_timer #(.CNT_W(W)) dut (
        .clk(clk), .rst(rst), .wr_en(wr_en), .wr_addr(wr_addr), .wr_data(wr_data),
        .gp_in(gp_in), .ch0_pin(ch0_pin), .ch1_pin(ch1_pin), .active_ch(active_ch),
        .switch_pending(switch_pending), .ovf(ovf), .count(count)
    );

    task automatic chk(input bit ok, input string tag, input int act, input int exp);
        n_chk++;
        if (!ok) begin
            n_fail++;
            $display("FAIL %s actual=%0d expected=%0d", tag, act, exp);
        end
    endtask

    // ---------------- reference model and scoreboard ----------------
    typedef struct packed {
        logic [W-1:0] cnt;
        logic p0, p1, lnk, act, pend, ov;
    } exp_t;

    exp_t q[$];

    logic [W-1:0] m_cnt, m_wrap, m_c0, m_c1, m_cv;
    logic [2:0]   m_k0, m_k1;
    logic         m_p0, m_p1, m_act, m_pend, m_ov, m_lk;

    always @(posedge clk) begin
        if (rst) begin
            m_cnt = '0; m_wrap = '1; m_c0 = '1; m_c1 = '1;
            m_k0 = '0; m_k1 = '0; m_p0 = 0; m_p1 = 0; m_act = 0; m_pend = 0;
        end else begin
            m_ov = (m_cnt == m_wrap);
            m_lk = m_k0[0];
            m_cv = (m_lk && m_act) ? m_c1 : m_c0;
            if (m_cnt == m_cv) m_p0 = m_k0[2];
            else if (m_ov && m_k0[1]) m_p0 = ~m_p0;
            if (!m_lk) begin
                if (m_cnt == m_c1) m_p1 = m_k1[2];
                else if (m_ov && m_k1[1]) m_p1 = ~m_p1;
            end
            if (!m_lk) begin
                m_act = 0; m_pend = 0;
            end else begin
                if (m_ov && m_pend) m_act = ~m_act;
                if (wr_en && wr_addr == 3'd1)      m_pend = (m_act != 1'b0);
                else if (wr_en && wr_addr == 3'd2) m_pend = (m_act != 1'b1);
                else if (m_ov)                     m_pend = 0;
            end
            if (wr_en) begin
                case (wr_addr)
                    3'd0: m_wrap = wr_data;
                    3'd1: m_c0   = wr_data;
                    3'd2: m_c1   = wr_data;
                    3'd3: m_k0   = wr_data[2:0];
                    3'd4: m_k1   = wr_data[2:0];
                    default: ;
                endcase
            end
            m_cnt = m_ov ? '0 : m_cnt + 1'b1;
        end
        q.push_back({m_cnt, m_p0, m_p1, m_k0[0], m_act, m_pend, (m_cnt == m_wrap)});
    end

    always @(negedge clk) begin
        if (q.size() > 0 && !done) begin
            exp_t e;
            e = q.pop_front();
            chk(count == e.cnt, "R2 count", count, e.cnt);
            chk(ovf == e.ov, "R2 ovf", ovf, e.ov);
            chk(ch0_pin == e.p0, "R4 ch0_pin", ch0_pin, e.p0);
            chk(ch1_pin == (e.lnk ? gp_in : e.p1), "R6 ch1_pin", ch1_pin, e.lnk ? gp_in : e.p1);
            chk(active_ch == e.act, "R8 active_ch", active_ch, e.act);
            chk(switch_pending == e.pend, "R9 switch_pending", switch_pending, e.pend);
        end
    end

    // ---------------- driver helpers ----------------
    task automatic tick();
        @(negedge clk);
        #1;
    endtask

    task automatic wr(input logic [2:0] a, input logic [W-1:0] d);
        wr_en = 1'b1; wr_addr = a; wr_data = d;
        tick();
        wr_en = 1'b0;
    endtask

    task automatic sync_wrap();
        tick();
        while (!ovf) tick();
    endtask

    task automatic measure(input bit sel, output int h);
        h = 0;
        repeat (10) begin
            tick();
            h += sel ? int'(ch1_pin) : int'(ch0_pin);
        end
    endtask

    initial begin
        #1_000_000;
        if (!done) begin
            done = 1;
            n_chk++; n_fail++;
            $display("FAIL watchdog actual=%0d expected=%0d", 1, 0);
            $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
            $finish;
        end
    end

    initial begin
        int h, h2;
        rst = 1; wr_en = 0; wr_addr = '0; wr_data = '0; gp_in = 0;
        repeat (4) tick();
        // R1 reset state
        chk(count == 0, "R1 count", count, 0);
        chk(ch0_pin == 0 && ch1_pin == 0, "R1 pins", {ch0_pin, ch1_pin}, 0);
        chk(active_ch == 0 && switch_pending == 0, "R1 link state", {active_ch, switch_pending}, 0);
        rst = 0;

        // R3 R4 active-high pulse: wrap 9, compare 3, invert + clear
        wr(3'd0, 9); wr(3'd1, 3); wr(3'd3, 8'b010);
        sync_wrap(); sync_wrap(); measure(0, h);
        chk(h == 4, "R4 active-high width", h, 4);

        // R4 active-low pulse: invert + set
        wr(3'd3, 8'b110);
        sync_wrap(); sync_wrap(); measure(0, h);
        chk(h == 6, "R4 active-low width", h, 6);

        // R5 compare above wrap: level flat per period, inverted next (R3)
        wr(3'd1, 20); wr(3'd3, 8'b010);
        sync_wrap(); measure(0, h); measure(0, h2);
        chk(h == 0 || h == 10, "R5 flat period", h, 0);
        chk(h2 == 10 - h, "R3 inversion at wrap", h2, 10 - h);

        // R6 independent channel 1
        wr(3'd2, 5); wr(3'd4, 8'b010); wr(3'd1, 3);
        sync_wrap(); sync_wrap(); measure(1, h);
        chk(h == 6, "R6 ch1 width", h, 6);

        // R7 link entry, channel 0 governs
        wr(3'd3, 8'b011);
        sync_wrap(); sync_wrap(); measure(0, h);
        chk(h == 4, "R7 linked ch0 width", h, 4);
        chk(active_ch == 0, "R7 active on entry", active_ch, 0);

        // R11 pass-through and ignored channel 1 control
        gp_in = 1; tick();
        chk(ch1_pin == 1, "R11 gp high", ch1_pin, 1);
        wr(3'd4, 8'b110);
        gp_in = 0; tick();
        chk(ch1_pin == 0, "R11 gp low", ch1_pin, 0);

        // R8 buffered handover at next wrap only
        sync_wrap(); tick();
        wr(3'd2, 6);
        chk(switch_pending == 1, "R8 pending set", switch_pending, 1);
        chk(active_ch == 0, "R8 no early switch", active_ch, 0);
        while (!ovf) tick();
        chk(active_ch == 0, "R8 still old at wrap", active_ch, 0);
        tick();
        chk(active_ch == 1, "R8 switched", active_ch, 1);
        chk(switch_pending == 0, "R9 pending cleared", switch_pending, 0);
        sync_wrap(); measure(0, h);
        chk(h == 7, "R8 new width", h, 7);

        // R9 last write wins
        sync_wrap(); tick();
        wr(3'd1, 2);
        chk(switch_pending == 1, "R9 pending after idle write", switch_pending, 1);
        wr(3'd2, 7);
        chk(switch_pending == 0, "R9 cancelled by active write", switch_pending, 0);
        sync_wrap(); tick();
        chk(active_ch == 1, "R9 kept active", active_ch, 1);
        sync_wrap(); measure(0, h);
        chk(h == 8, "R9 width from last write", h, 8);

        // R10 active register write acts within the period
        sync_wrap();
        h = 0;
        for (int i = 0; i < 10; i++) begin
            tick();
            h += int'(ch0_pin);
            if (i == 0) begin wr_en = 1; wr_addr = 3'd2; wr_data = 1; end
            if (i == 1) wr_en = 0;
        end
        chk(h == 2, "R10 immediate width", h, 2);
        chk(switch_pending == 0, "R10 no pending", switch_pending, 0);

        // R7 unlink returns active to 0
        wr(3'd3, 8'b000); tick();
        chk(active_ch == 0, "R7 active after unlink", active_ch, 0);

        // R2 full-width wrap
        wr(3'd0, 255);
        sync_wrap();
        chk(count == 255, "R2 count at wrap", count, 255);
        tick();
        chk(count == 0, "R2 count after wrap", count, 0);
        chk(ovf == 0, "R2 ovf single cycle", ovf, 0);

        repeat (3) tick();
        done = 1;
        $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
        $finish;
    end
endmodule